// File: doc/BRIEF.md
# Peripheral Reset Handshake Sequencer

This block takes a peripheral through a complete reset cycle by talking to a subsystem controller that exposes separate write-one strobes for setting and clearing the clock gate and the reset line, plus two status words that report what the controller has actually done. A single trigger starts four ordered phases. In each phase the block pulses exactly one strobe for one cycle, then checks bit 0 of the matching status word once per cycle until it shows the level that phase expects.

Every wait is bounded by a parameterised number of checks. If the level has not appeared by the last allowed check, the sequence is abandoned at once. The block then raises an error flag and records which phase (1 to 4) gave up. A sequence that runs to the end raises a done flag instead. Either flag stays until the next accepted trigger. A trigger that arrives while a sequence is running is dropped.

Top module: `periph_reset_seq`

## Requirements
- R1: After reset the block is idle: busy, done and error are 0, the failed-phase output is 0 and no strobe is active.
- R2: A trigger sampled while idle starts a sequence. From the next cycle busy is 1 and done, error and the failed-phase output are 0.
- R3: Strobes appear strictly one at a time, each for exactly one cycle, and only while busy. Their order is reset-assert, clock-disable, reset-release, clock-enable.
- R4: Each phase has its own expected level. Phase 1 (reset-assert) waits for reset status 1. Phase 2 (clock-disable) waits for clock status 0. Phase 3 (reset-release) waits for reset status 0. Phase 4 (clock-enable) waits for clock status 1. A phase's strobe is issued only after the previous phase has seen its level.
- R5: Only bit 0 of each status word is compared. The upper bits never affect progress or outcome.
- R6: A phase passes if its level is seen on any of its first POLL_LIMIT checks. The first check happens in the cycle after the strobe, and there is one check per cycle after that.
- R7: If POLL_LIMIT checks in a phase all miss, the sequence stops. Error becomes 1, busy becomes 0, the failed-phase output holds the phase number (1 to 4), and no later strobe is issued.
- R8: A trigger while busy is ignored. The running sequence keeps its timing and strobes, and no new sequence follows it.
- R9: Done and error are never both 1. Each holds its value while idle until the next accepted trigger.
- R10: A sequence occupies exactly the sum, over the phases it enters, of one strobe cycle plus the checks used. An aborted phase counts 1 + POLL_LIMIT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sequence trigger, sampled while idle |
| clk_stat_i | input | STAT_W | Clock status word; bit 0 is the clock-running level |
| rst_stat_i | input | STAT_W | Reset status word; bit 0 is the reset-held level |
| clk_en_stb_o | output | 1 | One-cycle clock-enable strobe |
| clk_dis_stb_o | output | 1 | One-cycle clock-disable strobe |
| rst_assert_stb_o | output | 1 | One-cycle reset-request strobe |
| rst_release_stb_o | output | 1 | One-cycle reset-release strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed all four phases |
| err_o | output | 1 | Last sequence timed out |
| fail_phase_o | output | 3 | Phase number 1..4 that timed out, 0 otherwise |

## Verification
The assertions assume that both status words are synchronous to the block's clock and that the trigger is a level sampled on clock edges. They also assume the controller's status follows the strobes and does not change spontaneously. None of this is needed for safety, but the expected cycle counts depend on it. The stimulus model changes status bits only on the falling edge and only a programmed number of cycles after it sees the matching strobe, with a code for "never responds". It returns both lines to their post-reset levels before every sequence, so each phase's response time is known exactly. It also drives the upper status bits with constant patterns that disagree with bit 0, which keeps them static during a sequence.

// File: rtl/periph_reset_seq_pkg.sv
package periph_reset_seq_pkg;

   localparam int NUM_PHASES = 4;
   localparam int PHASE_W    = 2;
   localparam int FAIL_W     = 3;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_STROBE = 2'd1,
      SEQ_POLL   = 2'd2
   } seq_state_t;

   typedef logic [PHASE_W-1:0] phase_t;

   // phase index 0..3: reset-assert, clock-disable, reset-release, clock-enable
   function automatic logic phase_target(input phase_t p);
      return (p == phase_t'(0)) || (p == phase_t'(3));
   endfunction

   // odd phases watch the clock line, even phases the reset line
   function automatic logic phase_uses_clk(input phase_t p);
      return p[0];
   endfunction

endpackage

// File: rtl/prs_poll_timer.sv
module prs_poll_timer #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic last_o
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clear_i) cnt <= '0;
      else if (step_i)  cnt <= cnt + 1'b1;
   end

   assign last_o = (cnt == CW'(LIMIT - 1));

   AST_EXPIRY_ENDS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !clear_i) |=> clear_i); // R6

   AST_NO_STEP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> !step_i); // R7
endmodule

// File: rtl/prs_strobe_decode.sv
module prs_strobe_decode
   import periph_reset_seq_pkg::*;
#(
   parameter int N = NUM_PHASES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire_i,
   input  phase_t       phase_i,
   output logic [N-1:0] stb_o
);
   for (genvar g = 0; g < N; g++) begin : g_stb
      assign stb_o[g] = fire_i && (phase_i == phase_t'(g));
   end

   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_o)); // R3

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o != '0) |=> (stb_o == '0)); // R3
endmodule

// File: rtl/prs_seq_ctrl.sv
module prs_seq_ctrl
   import periph_reset_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              clk_lvl_i,
   input  logic              rst_lvl_i,
   input  logic              poll_last_i,
   output logic              fire_o,
   output logic              poll_step_o,
   output logic              poll_clear_o,
   output phase_t            phase_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [FAIL_W-1:0] fail_phase_o
);
   seq_state_t state;
   phase_t     phase;
   logic       seen, hit;

   assign seen = phase_uses_clk(phase) ? clk_lvl_i : rst_lvl_i;
   assign hit  = (seen == phase_target(phase));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= SEQ_IDLE;
         phase        <= '0;
         done_o       <= 1'b0;
         err_o        <= 1'b0;
         fail_phase_o <= '0;
      end else begin
         case (state)
            SEQ_IDLE: if (start_i) begin
               state        <= SEQ_STROBE;
               phase        <= '0;
               done_o       <= 1'b0;
               err_o        <= 1'b0;
               fail_phase_o <= '0;
            end
            SEQ_STROBE: state <= SEQ_POLL;
            SEQ_POLL: begin
               if (hit) begin
                  if (phase == phase_t'(NUM_PHASES - 1)) begin
                     state  <= SEQ_IDLE;
                     done_o <= 1'b1;
                  end else begin
                     phase <= phase + 1'b1;
                     state <= SEQ_STROBE;
                  end
               end else if (poll_last_i) begin
                  state        <= SEQ_IDLE;
                  err_o        <= 1'b1;
                  fail_phase_o <= {1'b0, phase} + FAIL_W'(1);
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign busy_o       = (state != SEQ_IDLE);
   assign fire_o       = (state == SEQ_STROBE);
   assign poll_clear_o = (state != SEQ_POLL);
   assign poll_step_o  = (state == SEQ_POLL) && !hit && !poll_last_i;
   assign phase_o      = phase;

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R9

   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(done_o) && $stable(err_o) && $stable(fail_phase_o))); // R9

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (!done_o && !err_o && fail_phase_o == '0)); // R2

   AST_FAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (fail_phase_o >= FAIL_W'(1) && fail_phase_o <= FAIL_W'(NUM_PHASES))); // R7
endmodule

// File: rtl/periph_reset_seq.sv
module periph_reset_seq
   import periph_reset_seq_pkg::*;
#(
   parameter int POLL_LIMIT = 1000000,
   parameter int STAT_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [STAT_W-1:0] clk_stat_i,
   input  logic [STAT_W-1:0] rst_stat_i,
   output logic              clk_en_stb_o,
   output logic              clk_dis_stb_o,
   output logic              rst_assert_stb_o,
   output logic              rst_release_stb_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [FAIL_W-1:0] fail_phase_o
);
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("POLL_LIMIT must be at least 1");
   end
   if (STAT_W < 1) begin : g_bad_width
      $error("STAT_W must be at least 1");
   end

   if (STAT_W > 1) begin : g_wide_stat
      logic unused_hi_bits;
      assign unused_hi_bits = ^{clk_stat_i[STAT_W-1:1], rst_stat_i[STAT_W-1:1]};
   end

   logic                  fire, step, clear, last;
   phase_t                phase;
   logic [NUM_PHASES-1:0] stb;

   prs_seq_ctrl i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .clk_lvl_i    (clk_stat_i[0]),
      .rst_lvl_i    (rst_stat_i[0]),
      .poll_last_i  (last),
      .fire_o       (fire),
      .poll_step_o  (step),
      .poll_clear_o (clear),
      .phase_o      (phase),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .err_o        (err_o),
      .fail_phase_o (fail_phase_o)
   );

   prs_poll_timer #(.LIMIT(POLL_LIMIT)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .step_i  (step),
      .last_o  (last)
   );

   prs_strobe_decode #(.N(NUM_PHASES)) i_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (fire),
      .phase_i (phase),
      .stb_o   (stb)
   );

   assign rst_assert_stb_o  = stb[0];
   assign clk_dis_stb_o     = stb[1];
   assign rst_release_stb_o = stb[2];
   assign clk_en_stb_o      = stb[3];

   AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (stb != '0) |-> busy_o); // R3

   AST_NO_STROBE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (stb == '0)); // R7
endmodule

// File: tb/test_periph_reset_seq.sv
module test_periph_reset_seq;
   localparam int LIM = 8;
   localparam int SW  = 4;
   localparam int NV  = 8;
   localparam int NEVER = 255;

   // {d_rst_assert, d_clk_dis, d_rst_release, d_clk_en, hi_bits[2:0], expected_fail[3:0]}
   localparam logic [38:0] VEC [NV] = '{
      {8'd0, 8'd0, 8'd0,   8'd0,   3'd0, 4'd0},
      {8'd1, 8'd2, 8'd3,   8'd4,   3'd7, 4'd0},
      {8'd8, 8'd8, 8'd8,   8'd8,   3'd0, 4'd0},
      {8'd9, 8'd0, 8'd0,   8'd0,   3'd0, 4'd1},
      {8'd0, 8'd9, 8'd0,   8'd0,   3'd5, 4'd2},
      {8'd0, 8'd0, 8'd255, 8'd0,   3'd0, 4'd3},
      {8'd0, 8'd0, 8'd0,   8'd255, 3'd2, 4'd4},
      {8'd5, 8'd0, 8'd8,   8'd1,   3'd5, 4'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic rst_lvl, clk_lvl;
   logic [SW-2:0] hi_bits;
   logic [SW-1:0] clk_stat, rst_stat;
   logic clk_en_stb, clk_dis_stb, rst_assert_stb, rst_release_stb;
   logic busy, done, err;
   logic [2:0] fail_phase;

   assign clk_stat = {hi_bits, clk_lvl};
   assign rst_stat = {~hi_bits, rst_lvl};

   always #5 clk = ~clk;

   periph_reset_seq #(.POLL_LIMIT(LIM), .STAT_W(SW)) i_periph_reset_seq (
      .clk               (clk),
      .rst_n             (rst_n),
      .start_i           (start),
      .clk_stat_i        (clk_stat),
      .rst_stat_i        (rst_stat),
      .clk_en_stb_o      (clk_en_stb),
      .clk_dis_stb_o     (clk_dis_stb),
      .rst_assert_stb_o  (rst_assert_stb),
      .rst_release_stb_o (rst_release_stb),
      .busy_o            (busy),
      .done_o            (done),
      .err_o             (err),
      .fail_phase_o      (fail_phase)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   // status-line model state
   int dly [4];
   logic [SW-2:0] hi_req = '0;
   int init_tok = 0;
   int seen_tok;
   int pend_rst, pend_clk;
   logic tgt_rst, tgt_clk;
   int log_n;
   int log_code [4];
   bit multi;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // controller model: responds to strobes after a programmed delay
   initial begin
      rst_lvl = 1'b0; clk_lvl = 1'b1; hi_bits = '0;
      pend_rst = -1; pend_clk = -1; seen_tok = 0;
      log_n = 0; multi = 0; tgt_rst = 1'b0; tgt_clk = 1'b1;
      forever begin
         @(negedge clk);
         if (init_tok != seen_tok) begin
            seen_tok = init_tok;
            rst_lvl = 1'b0; clk_lvl = 1'b1; hi_bits = hi_req;
            pend_rst = -1; pend_clk = -1; log_n = 0; multi = 0;
         end
         if (pend_rst > 0) begin
            pend_rst--;
            if (pend_rst == 0) begin rst_lvl = tgt_rst; pend_rst = -1; end
         end
         if (pend_clk > 0) begin
            pend_clk--;
            if (pend_clk == 0) begin clk_lvl = tgt_clk; pend_clk = -1; end
         end
         if ((rst_assert_stb + clk_dis_stb + rst_release_stb + clk_en_stb) > 1) multi = 1;
         for (int k = 0; k < 4; k++) begin
            logic s;
            case (k)
               0: s = rst_assert_stb;
               1: s = clk_dis_stb;
               2: s = rst_release_stb;
               default: s = clk_en_stb;
            endcase
            if (s) begin
               if (log_n < 4) log_code[log_n] = k + 1;
               log_n++;
               if (dly[k] != NEVER) begin
                  if (k[0]) begin
                     tgt_clk = (k == 3);
                     if (dly[k] == 0) clk_lvl = tgt_clk; else pend_clk = dly[k];
                  end else begin
                     tgt_rst = (k == 0);
                     if (dly[k] == 0) rst_lvl = tgt_rst; else pend_rst = dly[k];
                  end
               end
            end
         end
      end
   end

   task automatic run_seq(input int d0, input int d1, input int d2, input int d3,
                          input logic [SW-2:0] hi, input int exp_fail, input bit mid_pulse);
      int cycles, ecyc, d [4];
      d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
      for (int k = 0; k < 4; k++) dly[k] = d[k];
      hi_req = hi;
      init_tok++;
      @(negedge clk);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && !done && !err && fail_phase == 0, "R2", "start clears flags",
            {busy, done, err}, 3'b100);
      cycles = 0;
      while (busy && cycles < 2000) begin
         cycles++;
         start = mid_pulse && (cycles == 3);
         @(negedge clk);
      end
      start = 1'b0;
      ecyc = 0;
      for (int p = 0; p < 4; p++) begin
         if (exp_fail == p + 1) begin
            ecyc += 1 + LIM;
            break;
         end
         ecyc += 1 + ((d[p] == 0) ? 1 : d[p]);
      end
      check(cycles == ecyc, "R10", "busy cycles", cycles, ecyc);
      check(done == (exp_fail == 0), "R9", "done flag", done, exp_fail == 0);
      check(err == (exp_fail != 0), "R7", "error flag", err, exp_fail != 0);
      check(fail_phase == exp_fail, "R7", "failed phase", fail_phase, exp_fail);
      check(log_n == ((exp_fail == 0) ? 4 : exp_fail), "R3", "strobe count",
            log_n, (exp_fail == 0) ? 4 : exp_fail);
      check(!multi, "R3", "strobes overlapping", multi, 0);
      for (int i = 0; i < 4 && i < log_n; i++)
         check(log_code[i] == i + 1, "R4", "strobe order", log_code[i], i + 1);
      if (hi != 0)
         check(done == (exp_fail == 0) && fail_phase == exp_fail, "R5",
               "upper status bits ignored", fail_phase, exp_fail);
      @(negedge clk);
      @(negedge clk);
      if (mid_pulse) check(!busy, "R8", "no retrigger from busy-time start", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !err && fail_phase == 0, "R1", "flags in reset",
            {busy, done, err, fail_phase}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({clk_en_stb, clk_dis_stb, rst_assert_stb, rst_release_stb} == 0 && !busy
            && !done && !err && fail_phase == 0, "R1", "idle after reset",
            {clk_en_stb, clk_dis_stb, rst_assert_stb, rst_release_stb, busy}, 0);

      for (int v = 0; v < NV; v++) begin
         run_seq(int'(VEC[v][38:31]), int'(VEC[v][30:23]), int'(VEC[v][22:15]),
                 int'(VEC[v][14:7]), VEC[v][6:4], int'(VEC[v][3:0]), 1'b0);
      end

      // R8: extra trigger while busy, no effect on timing or strobes
      run_seq(2, 1, 0, 3, 3'd0, 0, 1'b1);

      // R9: done held while idle
      repeat (6) @(negedge clk);
      check(done && !err, "R9", "done held while idle", {done, err}, 2'b10);

      // R6 boundary: last allowed check versus one beyond it in phase 4
      run_seq(0, 0, 0, LIM, 3'd0, 0, 1'b0);
      run_seq(0, 0, 0, LIM + 1, 3'd0, 4, 1'b0);

      // R9: error and failed phase held while idle
      repeat (6) @(negedge clk);
      check(err && !done && fail_phase == 4, "R9", "error held while idle",
            fail_phase, 4);

      // R2: new trigger after an error starts cleanly and completes
      run_seq(1, 1, 1, 1, 3'd4, 0, 1'b0);

      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule